// File: doc/BRIEF.md
# Opcode-Menu Software Flash Sequencer

This block is a flash command engine in which software does not pick a fixed cycle kind but an entry from an eight-slot opcode menu. Each slot holds an opcode byte and a 2-bit type. The type says whether the command carries the 24-bit address and whether its data phase reads or writes. A go write to the control word issues one command on a byte-level SPI master: the opcode first, then the optional address bytes, then the optional data bytes. Write data comes from the shared data buffer, and read data goes back into it at the same byte index.

An atomic mode wraps a write-type command for devices that need a write-enable first. The engine sends one of two programmable prefix opcodes as a frame of its own, then the main command. It then polls the device with read-status frames until the busy bit is clear, and only after that reports done. A sticky lockdown bit freezes the menu, prefix and type settings. An external range verdict, sampled at go, can refuse the command.

The FSM states are: IDLE, PREFIX (prefix frame), OPCODE, ADDR (three address bytes), DATA, POLL_CMD (status opcode 0x05), POLL_RD (status byte) and FINISH.

The transitions are:
- IDLE to PREFIX on an accepted atomic go, and IDLE to OPCODE on a plain go.
- PREFIX to OPCODE when its byte completes.
- OPCODE goes to ADDR, DATA, POLL_CMD or FINISH, according to the type, the data enable and the atomic mode.
- ADDR and DATA each leave on their last byte, for the next phase or for the polling or finishing path.
- POLL_CMD to POLL_RD.
- POLL_RD back to POLL_CMD while status bit 0 is set, or to FINISH once it is clear.
- FINISH to IDLE, raising done.

Top module: `menu_flash_seq`

## Requirements
- R1: After reset, the control word (register 0) reads 0 and no byte is started on the SPI master.
- R2: Menu slot i (i<4) is byte i of register 1, and slot i+4 is byte i of register 2. The type of slot i is bits 16+2i+1:16+2i of register 3, and each register reads back as written. Type codes: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R3: Register 3 bits 7:0 hold prefix 0 and bits 15:8 hold prefix 1. Control bit 11 set selects prefix 1 for an atomic command.
- R4: Writing control bit 15 sets a lockdown bit that reads back at bit 15 and stays set until reset. While it is set, writes to registers 1, 2 and 3 leave them unchanged.
- R5: A command frame is the opcode, then for types 2 and 3 the address register's low 24 bits, most significant byte first. The spi_last flag is set only on the final byte of the frame.
- R6: With control bit 22 set, bits 21:16 plus one data bytes follow the opcode and address. Read types store received byte k at buffer index k, and write types send buffer byte k.
- R7: With control bit 22 clear, no data bytes are sent.
- R8: Control bit 10 (atomic) first sends the selected prefix as a one-byte frame, then the command. It then repeats the two-byte frame 0x05, 0x00 until bit 0 of the received status byte is 0, and only then sets done.
- R9: An atomic go on a menu slot with a read type (0 or 2) sets cycle error (bit 3) and starts no SPI byte.
- R10: Go is control bit 9, and bits 14:12 pick the slot. Bit 0 (in progress) reads 1 from the cycle after an accepted go until the edge that sets done (bit 2) and clears bit 0.
- R11: Writing 1 to control bits 2, 3 or 4 clears done, cycle error or access error.
- R12: If range_deny is high at a go, access error (bit 4) is set and no SPI byte is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 menu low, 2 menu high, 3 prefix and types |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| range_deny | input | 1 | Range check verdict for the command, sampled at go |
| flash_addr | input | 24 | Shared flash address register |
| buf_idx | output | 6 | Data buffer byte index |
| buf_rdata | input | 8 | Data buffer byte at buf_idx |
| buf_we | output | 1 | Store received byte into the data buffer |
| buf_wdata | output | 8 | Byte to store |
| spi_start | output | 1 | Start one byte transfer |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Release chip select after this byte |
| spi_done | input | 1 | Byte transfer complete |
| spi_rx | input | 8 | Byte received, valid with spi_done |

## Verification
A register write is latched at the next rising edge, so the bench reads it back in the next cycle. The in-progress bit is checked in the first read after the go, because it is set at that same edge. Each SPI byte starts one cycle after the engine enters a byte state or after the previous byte completes. The bench's byte model answers four cycles after each start. The bench therefore waits for the done bit by polling the control word rather than by counting cycles. After done it compares the full logged byte and frame-end sequence and the buffer contents. Refused commands are checked in the cycle after the go, and the byte log is checked to be unchanged.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFIX,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] STATUS_OPCODE = 8'h05;

    localparam int CTL_CIP   = 0;
    localparam int CTL_DONE  = 2;
    localparam int CTL_ERR   = 3;
    localparam int CTL_AEL   = 4;
    localparam int CTL_GO    = 9;
    localparam int CTL_ATOM  = 10;
    localparam int CTL_PSEL  = 11;
    localparam int CTL_IDX   = 12;
    localparam int CTL_LOCK  = 15;
    localparam int CTL_CNT   = 16;
    localparam int CTL_DEN   = 22;
endpackage

// File: rtl/mfs_menu_regs.sv
module mfs_menu_regs #(
    parameter int N_ENTRIES = 8,
    parameter int OP_W      = 8,
    localparam int PER_WORD = 32 / OP_W,
    localparam int N_WORDS  = N_ENTRIES / PER_WORD,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic [N_WORDS-1:0]         we_menu,
    input  logic                       we_pfx,
    input  logic [31:0]                wdata,
    input  logic [IDX_W-1:0]           sel_idx,
    input  logic                       sel_pfx,
    output logic [OP_W-1:0]            opcode,
    output logic [1:0]                 optype,
    output logic [OP_W-1:0]            prefix,
    output logic [N_ENTRIES*OP_W-1:0]  menu_rd,
    output logic [2*N_ENTRIES-1:0]     type_rd,
    output logic [2*OP_W-1:0]          pfx_rd
);
    logic [OP_W-1:0]   op_q [N_ENTRIES];
    logic [1:0]        ty_q [N_ENTRIES];
    logic [2*OP_W-1:0] pfx_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        localparam int WORD = g / PER_WORD;
        localparam int LANE = g % PER_WORD;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q[g] <= '0;
                ty_q[g] <= '0;
            end else begin
                if (!lock && we_menu[WORD]) op_q[g] <= wdata[LANE*OP_W +: OP_W];
                if (!lock && we_pfx)        ty_q[g] <= wdata[16 + 2*g +: 2];
            end
        end
        assign menu_rd[g*OP_W +: OP_W] = op_q[g];
        assign type_rd[2*g +: 2]       = ty_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            pfx_q <= '0;
        else if (!lock && we_pfx) pfx_q <= wdata[2*OP_W-1:0];
    end

    assign pfx_rd = pfx_q;
    assign opcode = op_q[sel_idx];
    assign optype = ty_q[sel_idx];
    assign prefix = sel_pfx ? pfx_q[2*OP_W-1:OP_W] : pfx_q[OP_W-1:0];

    assert_locked_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(menu_rd) && $stable(type_rd) && $stable(pfx_rd)));
endmodule

// File: rtl/mfs_engine.sv
module mfs_engine
    import mfs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int MAX_BYTES = 64,
    localparam int CNT_W      = $clog2(MAX_BYTES),
    localparam int ADDR_BYTES = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              atomic,
    input  logic              data_en,
    input  logic [CNT_W-1:0]  count_m1,
    input  logic [7:0]        opcode,
    input  logic [1:0]        optype,
    input  logic [7:0]        prefix,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        buf_rdata,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx,
    output logic              busy,
    output logic              fin,
    output logic              spi_start,
    output logic [7:0]        spi_tx,
    output logic              spi_last,
    output logic [CNT_W-1:0]  buf_idx,
    output logic              buf_we,
    output logic [7:0]        buf_wdata
);
    seq_state_e        state_q, state_d;
    logic              wait_q;
    logic [CNT_W-1:0]  byte_q;
    logic [7:0]        op_q, pfx_q;
    logic [1:0]        ty_q;
    logic [ADDR_W-1:0] addr_q;
    logic              atom_q, den_q;
    logic [CNT_W-1:0]  cnt_q;

    logic       byte_done, has_addr, is_write, addr_end, data_end;
    seq_state_e after_cmd, after_data;

    assign byte_done  = wait_q && spi_done;
    assign has_addr   = ty_q[1];
    assign is_write   = ty_q[0];
    assign addr_end   = (byte_q == CNT_W'(ADDR_BYTES - 1));
    assign data_end   = (byte_q == cnt_q);
    assign after_data = atom_q ? ST_POLL_CMD : ST_FINISH;
    assign after_cmd  = den_q ? ST_DATA : after_data;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = atomic ? ST_PREFIX : ST_OPCODE;
            ST_PREFIX:   if (byte_done) state_d = ST_OPCODE;
            ST_OPCODE:   if (byte_done) state_d = has_addr ? ST_ADDR : after_cmd;
            ST_ADDR:     if (byte_done && addr_end) state_d = after_cmd;
            ST_DATA:     if (byte_done && data_end) state_d = after_data;
            ST_POLL_CMD: if (byte_done) state_d = ST_POLL_RD;
            ST_POLL_RD:  if (byte_done) state_d = spi_rx[0] ? ST_POLL_CMD : ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= 1'b0;
            byte_q  <= '0;
            op_q    <= '0;
            pfx_q   <= '0;
            ty_q    <= '0;
            addr_q  <= '0;
            atom_q  <= 1'b0;
            den_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (spi_start)     wait_q <= 1'b1;
            else if (spi_done) wait_q <= 1'b0;
            if (state_d != state_q) byte_q <= '0;
            else if (byte_done)     byte_q <= byte_q + 1'b1;
            if (state_q == ST_IDLE && start) begin
                op_q   <= opcode;
                pfx_q  <= prefix;
                ty_q   <= optype;
                addr_q <= addr;
                atom_q <= atomic;
                den_q  <= data_en;
                cnt_q  <= count_m1;
            end
        end
    end

    always_comb begin
        spi_start = 1'b0;
        spi_tx    = 8'h00;
        spi_last  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: ;
            ST_PREFIX: begin
                spi_start = !wait_q;
                spi_tx    = pfx_q;
                spi_last  = 1'b1;
            end
            ST_OPCODE: begin
                spi_start = !wait_q;
                spi_tx    = op_q;
                spi_last  = !has_addr && !den_q;
            end
            ST_ADDR: begin
                spi_start = !wait_q;
                spi_tx    = 8'(addr_q >> (8 * (ADDR_BYTES - 1 - int'(byte_q))));
                spi_last  = addr_end && !den_q;
            end
            ST_DATA: begin
                spi_start = !wait_q;
                spi_tx    = is_write ? buf_rdata : 8'h00;
                spi_last  = data_end;
            end
            ST_POLL_CMD: begin
                spi_start = !wait_q;
                spi_tx    = STATUS_OPCODE;
            end
            ST_POLL_RD: begin
                spi_start = !wait_q;
                spi_last  = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign fin       = (state_q == ST_FINISH);
    assign buf_idx   = byte_q;
    assign buf_we    = (state_q == ST_DATA) && byte_done && !is_write;
    assign buf_wdata = spi_rx;

    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !spi_start);
    assert_poll_only_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL_RD && byte_done) |-> atom_q);
    assert_no_read_store_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (state_q == ST_DATA && !is_write));
endmodule

// File: rtl/menu_flash_seq.sv
module menu_flash_seq
    import mfs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int MAX_BYTES = 64,
    parameter int N_ENTRIES = 8,
    localparam int CNT_W    = $clog2(MAX_BYTES),
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              range_deny,
    input  logic [ADDR_W-1:0] flash_addr,
    output logic [CNT_W-1:0]  buf_idx,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              spi_start,
    output logic [7:0]        spi_tx,
    output logic              spi_last,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx
);
    logic             lock_q, cip_q, done_q, err_q, ael_q;
    logic             atom_q, psel_q, den_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;

    logic             wr_ctrl, go, bad_atomic, eng_start, eng_busy, eng_fin;
    logic [IDX_W-1:0] sel_idx;
    logic [7:0]       cur_op, cur_pfx;
    logic [1:0]       cur_ty;
    logic [8*N_ENTRIES-1:0] menu_rd;
    logic [2*N_ENTRIES-1:0] type_rd;
    logic [15:0]      pfx_rd;
    logic [31:0]      ctrl_rd;

    assign wr_ctrl    = reg_we && (reg_addr == 2'd0);
    assign go         = wr_ctrl && reg_wdata[CTL_GO] && !cip_q;
    assign sel_idx    = wr_ctrl ? reg_wdata[CTL_IDX +: IDX_W] : idx_q;
    assign bad_atomic = reg_wdata[CTL_ATOM] && !cur_ty[0];
    assign eng_start  = go && !range_deny && !bad_atomic;

    mfs_menu_regs #(.N_ENTRIES(N_ENTRIES), .OP_W(8)) u_menu (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (lock_q),
        .we_menu ({reg_we && reg_addr == 2'd2, reg_we && reg_addr == 2'd1}),
        .we_pfx  (reg_we && reg_addr == 2'd3),
        .wdata   (reg_wdata),
        .sel_idx (sel_idx),
        .sel_pfx (reg_wdata[CTL_PSEL]),
        .opcode  (cur_op),
        .optype  (cur_ty),
        .prefix  (cur_pfx),
        .menu_rd (menu_rd),
        .type_rd (type_rd),
        .pfx_rd  (pfx_rd)
    );

    mfs_engine #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .atomic    (reg_wdata[CTL_ATOM]),
        .data_en   (reg_wdata[CTL_DEN]),
        .count_m1  (reg_wdata[CTL_CNT +: CNT_W]),
        .opcode    (cur_op),
        .optype    (cur_ty),
        .prefix    (cur_pfx),
        .addr      (flash_addr),
        .buf_rdata (buf_rdata),
        .spi_done  (spi_done),
        .spi_rx    (spi_rx),
        .busy      (eng_busy),
        .fin       (eng_fin),
        .spi_start (spi_start),
        .spi_tx    (spi_tx),
        .spi_last  (spi_last),
        .buf_idx   (buf_idx),
        .buf_we    (buf_we),
        .buf_wdata (buf_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0; cip_q <= 1'b0; done_q <= 1'b0;
            err_q  <= 1'b0; ael_q <= 1'b0; atom_q <= 1'b0;
            psel_q <= 1'b0; den_q <= 1'b0; idx_q  <= '0; cnt_q <= '0;
        end else begin
            if (wr_ctrl) begin
                if (reg_wdata[CTL_DONE]) done_q <= 1'b0;
                if (reg_wdata[CTL_ERR])  err_q  <= 1'b0;
                if (reg_wdata[CTL_AEL])  ael_q  <= 1'b0;
                if (reg_wdata[CTL_LOCK]) lock_q <= 1'b1;
                if (!cip_q) begin
                    idx_q  <= reg_wdata[CTL_IDX +: IDX_W];
                    atom_q <= reg_wdata[CTL_ATOM];
                    psel_q <= reg_wdata[CTL_PSEL];
                    den_q  <= reg_wdata[CTL_DEN];
                    cnt_q  <= reg_wdata[CTL_CNT +: CNT_W];
                end
            end
            if (go) begin
                if (range_deny)      ael_q <= 1'b1;
                else if (bad_atomic) err_q <= 1'b1;
                else                 cip_q <= 1'b1;
            end
            if (eng_fin) begin
                cip_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTL_CIP]  = cip_q;
        ctrl_rd[CTL_DONE] = done_q;
        ctrl_rd[CTL_ERR]  = err_q;
        ctrl_rd[CTL_AEL]  = ael_q;
        ctrl_rd[CTL_ATOM] = atom_q;
        ctrl_rd[CTL_PSEL] = psel_q;
        ctrl_rd[CTL_IDX +: IDX_W] = idx_q;
        ctrl_rd[CTL_LOCK] = lock_q;
        ctrl_rd[CTL_CNT +: CNT_W] = cnt_q;
        ctrl_rd[CTL_DEN]  = den_q;
    end

    always_comb begin
        unique case (reg_addr)
            2'd0: reg_rdata = ctrl_rd;
            2'd1: reg_rdata = menu_rd[31:0];
            2'd2: reg_rdata = menu_rd[63:32];
            default: reg_rdata = {type_rd, pfx_rd};
        endcase
    end

    assert_done_ends_cip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !cip_q);
    assert_bad_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !range_deny && bad_atomic) |=> (err_q && !cip_q && !eng_busy));
    assert_deny_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (go && range_deny) |=> (ael_q && !eng_busy));
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    assert_cip_tracks_engine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> cip_q);
endmodule

// File: tb/sim_menu_flash_seq.sv
module sim_menu_flash_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        range_deny = 1'b0;
    logic [23:0] flash_addr = '0;
    logic [5:0]  buf_idx;
    logic [7:0]  buf_rdata;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic        spi_start, spi_last;
    logic [7:0]  spi_tx;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0] bmem [64];
    logic [7:0] log_tx [256];
    logic       log_last [256];
    int         nlog = 0;
    int         lat = 0;
    int         busy_left = 0;
    logic       poll_next = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    menu_flash_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .range_deny(range_deny),
        .flash_addr(flash_addr), .buf_idx(buf_idx), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .spi_start(spi_start),
        .spi_tx(spi_tx), .spi_last(spi_last), .spi_done(spi_done), .spi_rx(spi_rx)
    );

    assign buf_rdata = bmem[buf_idx];

    always @(posedge clk) begin
        if (buf_we) bmem[buf_idx] <= buf_wdata;
    end

    always @(posedge clk) begin
        spi_done <= 1'b0;
        if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) spi_done <= 1'b1;
        end
        if (spi_start) begin
            log_tx[nlog]   <= spi_tx;
            log_last[nlog] <= spi_last;
            nlog <= nlog + 1;
            lat  <= 3;
            if (poll_next) begin
                spi_rx    <= (busy_left > 0) ? 8'h01 : 8'h00;
                if (busy_left > 0) busy_left <= busy_left - 1;
                poll_next <= 1'b0;
            end else begin
                spi_rx    <= 8'hA0 + 8'(nlog);
                poll_next <= (spi_tx == 8'h05) && !spi_last;
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input int idx, input bit atom, input bit psel, input bit den, input int cnt);
        return (32'd1 << 9) | (32'(idx) << 12) | (32'(atom) << 10) | (32'(psel) << 11)
             | (32'(den) << 22) | (32'(cnt) << 16);
    endfunction

    task automatic wait_done(input string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (v[2]) break;
        end
        check(req, "done set, in-progress clear", {30'd0, v[2], v[0]}, 32'h2);
    endtask

    task automatic check_log(input string req, input int at, input logic [7:0] tx, input logic last);
        check(req, $sformatf("byte %0d", at), {23'd0, log_last[at], log_tx[at]}, {23'd0, last, tx});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v);
        check("R1", "control after reset", v, 32'h0);
        check("R1", "no bytes after reset", 32'(nlog), 32'd0);
    endtask

    task automatic t_menu;
        logic [31:0] v;
        wr(2'd1, 32'h0B03029F);
        wr(2'd2, 32'hABD82001);
        wr(2'd3, 32'h3DAC5006);
        rd(2'd1, v); check("R2", "menu low", v, 32'h0B03029F);
        rd(2'd2, v); check("R2", "menu high", v, 32'hABD82001);
        rd(2'd3, v); check("R3", "prefix and types", v, 32'h3DAC5006);
    endtask

    task automatic t_read_addr;
        logic [31:0] v;
        flash_addr = 24'h123456;
        wr(2'd0, ctl(2, 0, 0, 1, 3));
        rd(2'd0, v);
        check("R10", "in progress after go", {31'd0, v[0]}, 32'd1);
        wait_done("R10");
        check("R5", "byte count", 32'(nlog), 32'd8);
        check_log("R5", 0, 8'h03, 1'b0);
        check_log("R5", 1, 8'h12, 1'b0);
        check_log("R5", 2, 8'h34, 1'b0);
        check_log("R5", 3, 8'h56, 1'b0);
        check_log("R6", 4, 8'h00, 1'b0);
        check_log("R6", 7, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++)
            check("R6", $sformatf("buffer %0d", k), 32'(bmem[k]), 32'(8'hA4 + 8'(k)));
    endtask

    task automatic t_no_data;
        logic [31:0] v;
        wr(2'd0, 32'h0000_001C);
        rd(2'd0, v);
        check("R11", "done cleared", {31'd0, v[2]}, 32'd0);
        wr(2'd0, ctl(0, 0, 0, 0, 5));
        wait_done("R7");
        check("R7", "single byte", 32'(nlog), 32'd9);
        check_log("R7", 8, 8'h9F, 1'b1);
        wr(2'd0, 32'h0000_001C);
    endtask

    task automatic t_atomic_write;
        flash_addr = 24'h0A0B0C;
        bmem[0] = 8'h11; bmem[1] = 8'h22;
        busy_left = 2;
        wr(2'd0, ctl(1, 1, 1, 1, 1));
        wait_done("R8");
        check("R8", "byte count", 32'(nlog), 32'd22);
        check_log("R3", 9, 8'h50, 1'b1);
        check_log("R8", 10, 8'h02, 1'b0);
        check_log("R5", 11, 8'h0A, 1'b0);
        check_log("R5", 13, 8'h0C, 1'b0);
        check_log("R6", 14, 8'h11, 1'b0);
        check_log("R6", 15, 8'h22, 1'b1);
        for (int p = 0; p < 3; p++) begin
            check_log("R8", 16 + 2*p, 8'h05, 1'b0);
            check_log("R8", 17 + 2*p, 8'h00, 1'b1);
        end
        wr(2'd0, 32'h0000_001C);
    endtask

    task automatic t_bad_atomic;
        logic [31:0] v;
        wr(2'd0, ctl(2, 1, 0, 0, 0));
        rd(2'd0, v);
        check("R9", "error set, not in progress", {v[3], v[2], v[0]}, 32'b100);
        repeat (10) @(negedge clk);
        check("R9", "no bytes", 32'(nlog), 32'd22);
        wr(2'd0, 32'h0000_0008);
        rd(2'd0, v);
        check("R11", "error cleared", {31'd0, v[3]}, 32'd0);
    endtask

    task automatic t_deny;
        logic [31:0] v;
        @(negedge clk); range_deny = 1'b1;
        wr(2'd0, ctl(0, 0, 0, 0, 0));
        range_deny = 1'b0;
        rd(2'd0, v);
        check("R12", "access error set", {v[4], v[0]}, 32'b10);
        repeat (10) @(negedge clk);
        check("R12", "no bytes", 32'(nlog), 32'd22);
        wr(2'd0, 32'h0000_0010);
        rd(2'd0, v);
        check("R11", "access error cleared", {31'd0, v[4]}, 32'd0);
    endtask

    task automatic t_prefix0;
        busy_left = 0;
        wr(2'd0, ctl(4, 1, 0, 0, 0));
        wait_done("R3");
        check("R8", "byte count", 32'(nlog), 32'd26);
        check_log("R3", 22, 8'h06, 1'b1);
        check_log("R5", 23, 8'h01, 1'b1);
        check_log("R8", 24, 8'h05, 1'b0);
        check_log("R8", 25, 8'h00, 1'b1);
        wr(2'd0, 32'h0000_001C);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        wr(2'd0, 32'h0000_8000);
        rd(2'd0, v);
        check("R4", "lock bit", {31'd0, v[15]}, 32'd1);
        wr(2'd1, 32'h11223344);
        wr(2'd3, 32'h00000000);
        rd(2'd1, v); check("R4", "menu low frozen", v, 32'h0B03029F);
        rd(2'd3, v); check("R4", "prefix and types frozen", v, 32'h3DAC5006);
        wr(2'd0, 32'h0000_0000);
        rd(2'd0, v);
        check("R4", "lock sticky", {31'd0, v[15]}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_menu();
        t_read_addr();
        t_no_data();
        t_atomic_write();
        t_bad_atomic();
        t_deny();
        t_prefix0();
        t_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule